// File: doc/BRIEF.md
# Chipset Configuration and Upper-Memory Routing Controller

This block gives system software access to a bank of byte-wide chipset configuration registers through two 8-bit I/O ports: a pointer port that selects a register and a window port that reads or writes the selected register. A fixed identification byte sits at pointer value zero. Writes are accepted only for a contiguous band of pointer values. Writes to any pointer outside that band are dropped.

Six of the registers route the upper-memory area from A0000h to FFFFFh, one register per 64 KB segment. Each register holds four 2-bit codes, one for each 16 KB granule. A purely combinational lookup takes a 20-bit memory address. It reports whether a read of that address is served by on-board DRAM or passed to the expansion bus, and does the same for a write. The memory controller uses these two flags on every cycle.

Two more ports in the same I/O group act through their accesses, not through stored data. A read of the third port enables the A20 gate and a write to it disables the gate. A read of the fourth port sends a single-clock soft-reset pulse to the CPU.

Top module: `cfg_shadow_ctrl`

## Requirements
- R1: A write to the pointer port (IO_BASE, default 0xEC) stores all 8 bits as the current pointer. A read of the pointer port in the same cycle as `io_rd_i` returns that pointer on `io_rdata_o`.
- R2: A read of the window port (IO_BASE+1) returns the register selected by the pointer. A write to the window port with the pointer in 0x01..0x24 stores the byte, and the stored byte reads back.
- R3: A window write with the pointer at 0x00 or in 0x25..0xFF changes no register. A later read at that pointer returns the same value as before the write.
- R4: Pointer 0x00 always reads 0x90. Pointers 0x25..0xFF read 0x00.
- R5: Registers 0x0D, 0x0E, 0x0F, 0x10, 0x11 and 0x12 route the segments A0000h, B0000h, C0000h, D0000h, E0000h and F0000h. Bits [1:0] of a register cover the lowest 16 KB granule of its segment. Each following 2-bit field covers the next higher granule, so bits [7:6] cover the highest.
- R6: In a routing code, bit 1 set sends reads to internal DRAM (`rd_int_o`=1) and bit 0 set sends writes to internal DRAM (`wr_int_o`=1). The values are: 0 = both external, 1 = read external and write internal, 2 = read internal and write external, 3 = both internal.
- R7: Any address below A0000h gives `rd_int_o`=1 and `wr_int_o`=1.
- R8: A read of IO_BASE+2 sets `a20_en_o` from the next cycle. A write to IO_BASE+2 clears it from the next cycle. A write wins over a read in the same cycle.
- R9: A single read of IO_BASE+3 drives `soft_rst_o` high for exactly the one following cycle.
- R10: `io_rdata_o` is 0xFF for a read of IO_BASE+2, a read of IO_BASE+3, a read of any port outside the group, and whenever `io_rd_i` is low.
- R11: After reset the pointer is 0x00, all writable registers are 0x00, `a20_en_o` and `soft_rst_o` are low, and every upper-memory granule routes both reads and writes externally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 8 | I/O write data |
| io_wr_i | input | 1 | I/O write strobe, one cycle per access |
| io_rd_i | input | 1 | I/O read strobe, one cycle per access |
| io_rdata_o | output | 8 | I/O read data, combinational |
| mem_addr_i | input | 20 | Memory address to route |
| rd_int_o | output | 1 | Reads of `mem_addr_i` go to internal DRAM |
| wr_int_o | output | 1 | Writes to `mem_addr_i` go to internal DRAM |
| a20_en_o | output | 1 | A20 gate enable |
| soft_rst_o | output | 1 | CPU soft-reset pulse |

## Verification
The bench builds the block with its default parameters: port group at 0xEC, writable band 0x01..0x24, six 64 KB segments starting at A0000h, and 16 KB granules. With these values a short run can write to both edges of the writable band and to pointers just outside it. It can also place all four routing codes in the granules of a single segment, in both ascending and descending order. Finally, it can probe addresses at both ends of the shadow area: 9FFFFh, A0000h and FFFFFh.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  // routing flags, bit order matches the 2-bit code {read, write}
  typedef struct packed {
    logic rd_int;
    logic wr_int;
  } route_t;

  typedef struct packed {
    logic ptr;
    logic win;
    logic a20;
    logic rst;
  } port_sel_t;
endpackage

// File: rtl/cfg_io_decode.sv
module cfg_io_decode
  import cfg_shadow_pkg::*;
#(
  parameter logic [15:0] IO_BASE = 16'h00EC
) (
  input  logic [15:0] io_addr_i,
  output port_sel_t   sel_o
);
  localparam int unsigned NPORTS = 4;

  logic [NPORTS-1:0] hit;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign hit[p] = (io_addr_i == IO_BASE + 16'(p));
  end

  assign sel_o = '{ptr: hit[0], win: hit[1], a20: hit[2], rst: hit[3]};
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter logic [7:0]  ID_VALUE = 8'h90,
  parameter int unsigned REG_LO   = 1,
  parameter int unsigned REG_HI   = 36,
  parameter int unsigned SEG_IDX  = 13,
  parameter int unsigned NUM_SEGS = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ptr_wr_i,
  input  logic                      win_wr_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                ptr_o,
  output logic [7:0]                rdata_o,
  output logic [NUM_SEGS-1:0][7:0]  seg_cfg_o
);
  logic [7:0] ptr_q;
  logic [7:0] regs_q [REG_LO:REG_HI];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (ptr_wr_i) ptr_q <= wdata_i;
  end

  // only the writable band is stored; other pointers decode to constants
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = REG_LO; i <= REG_HI; i++) regs_q[i] <= '0;
    end else if (win_wr_i) begin
      for (int i = REG_LO; i <= REG_HI; i++)
        if (ptr_q == 8'(i)) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ptr_q == 8'h00) rdata_o = ID_VALUE;
    for (int i = REG_LO; i <= REG_HI; i++)
      if (ptr_q == 8'(i)) rdata_o = regs_q[i];
  end

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    assign seg_cfg_o[g] = regs_q[SEG_IDX+g];
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/shadow_lookup.sv
module shadow_lookup
  import cfg_shadow_pkg::*;
#(
  parameter int unsigned MEM_AW      = 20,
  parameter int unsigned SEG_AW      = 16,
  parameter int unsigned GRAN_AW     = 14,
  parameter int unsigned SHADOW_BASE = 32'h000A_0000,
  parameter int unsigned NUM_SEGS    = 6
) (
  input  logic [MEM_AW-1:0]         mem_addr_i,
  input  logic [NUM_SEGS-1:0][7:0]  seg_cfg_i,
  output route_t                    route_o
);
  localparam int unsigned TAG_W     = MEM_AW - SEG_AW;
  localparam int unsigned GSEL_W    = SEG_AW - GRAN_AW;
  localparam int unsigned FIRST_TAG = SHADOW_BASE >> SEG_AW;

  logic [TAG_W-1:0]  tag;
  logic [GSEL_W-1:0] gsel;
  logic [7:0]        seg_byte;
  logic [7:0]        shifted;
  logic              hit;

  assign tag  = mem_addr_i[MEM_AW-1:SEG_AW];
  assign gsel = mem_addr_i[SEG_AW-1:GRAN_AW];

  always_comb begin
    seg_byte = '0;
    hit      = 1'b0;
    for (int s = 0; s < NUM_SEGS; s++) begin
      if (tag == TAG_W'(FIRST_TAG + s)) begin
        seg_byte = seg_cfg_i[s];
        hit      = 1'b1;
      end
    end
    shifted = seg_byte >> {gsel, 1'b0};
    // below the shadow area everything is plain DRAM
    route_o = hit ? route_t'(shifted[1:0]) : '{rd_int: 1'b1, wr_int: 1'b1};
  end
endmodule

// File: rtl/cfg_sys_ctrl.sv
module cfg_sys_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a20_set_i,
  input  logic a20_clr_i,
  input  logic rst_req_i,
  output logic a20_en_o,
  output logic soft_rst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a20_en_o   <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      if (a20_clr_i)      a20_en_o <= 1'b0;
      else if (a20_set_i) a20_en_o <= 1'b1;
      soft_rst_o <= rst_req_i;
    end
  end
endmodule

// File: rtl/cfg_shadow_ctrl.sv
module cfg_shadow_ctrl
  import cfg_shadow_pkg::*;
#(
  parameter logic [15:0] IO_BASE     = 16'h00EC,
  parameter logic [7:0]  ID_VALUE    = 8'h90,
  parameter int unsigned REG_LO      = 1,
  parameter int unsigned REG_HI      = 36,
  parameter int unsigned SEG_IDX     = 13,
  parameter int unsigned MEM_AW      = 20,
  parameter int unsigned SEG_AW      = 16,
  parameter int unsigned GRAN_AW     = 14,
  parameter int unsigned SHADOW_BASE = 32'h000A_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       io_addr_i,
  input  logic [7:0]        io_wdata_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  output logic [7:0]        io_rdata_o,
  input  logic [MEM_AW-1:0] mem_addr_i,
  output logic              rd_int_o,
  output logic              wr_int_o,
  output logic              a20_en_o,
  output logic              soft_rst_o
);
  localparam int unsigned NUM_SEGS = ((2 ** MEM_AW) - SHADOW_BASE) >> SEG_AW;

  port_sel_t                sel;
  logic [7:0]               ptr;
  logic [7:0]               win_rdata;
  logic [NUM_SEGS-1:0][7:0] seg_cfg;
  route_t                   route;

  cfg_io_decode #(.IO_BASE(IO_BASE)) u_decode (
    .io_addr_i (io_addr_i),
    .sel_o     (sel)
  );

  cfg_regfile #(
    .ID_VALUE (ID_VALUE),
    .REG_LO   (REG_LO),
    .REG_HI   (REG_HI),
    .SEG_IDX  (SEG_IDX),
    .NUM_SEGS (NUM_SEGS)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptr_wr_i  (io_wr_i & sel.ptr),
    .win_wr_i  (io_wr_i & sel.win),
    .wdata_i   (io_wdata_i),
    .ptr_o     (ptr),
    .rdata_o   (win_rdata),
    .seg_cfg_o (seg_cfg)
  );

  shadow_lookup #(
    .MEM_AW      (MEM_AW),
    .SEG_AW      (SEG_AW),
    .GRAN_AW     (GRAN_AW),
    .SHADOW_BASE (SHADOW_BASE),
    .NUM_SEGS    (NUM_SEGS)
  ) u_lookup (
    .mem_addr_i (mem_addr_i),
    .seg_cfg_i  (seg_cfg),
    .route_o    (route)
  );

  cfg_sys_ctrl u_sys (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a20_set_i  (io_rd_i & sel.a20),
    .a20_clr_i  (io_wr_i & sel.a20),
    .rst_req_i  (io_rd_i & sel.rst),
    .a20_en_o   (a20_en_o),
    .soft_rst_o (soft_rst_o)
  );

  always_comb begin
    io_rdata_o = 8'hFF;
    if (io_rd_i) begin
      if (sel.ptr)      io_rdata_o = ptr;
      else if (sel.win) io_rdata_o = win_rdata;
    end
  end

  assign rd_int_o = route.rd_int;
  assign wr_int_o = route.wr_int;
endmodule

// File: rtl/cfg_shadow_ctrl_chk.sv
module cfg_shadow_ctrl_chk #(
  parameter logic [15:0] IO_BASE     = 16'h00EC,
  parameter int unsigned MEM_AW      = 20,
  parameter int unsigned SHADOW_BASE = 32'h000A_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       io_addr_i,
  input logic [7:0]        io_wdata_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [7:0]        io_rdata_o,
  input logic [MEM_AW-1:0] mem_addr_i,
  input logic              rd_int_o,
  input logic              wr_int_o,
  input logic              a20_en_o,
  input logic              soft_rst_o
);
  localparam logic [15:0] PTR_PORT = IO_BASE;
  localparam logic [15:0] WIN_PORT = IO_BASE + 16'd1;
  localparam logic [15:0] A20_PORT = IO_BASE + 16'd2;
  localparam logic [15:0] RST_PORT = IO_BASE + 16'd3;
  localparam logic [MEM_AW-1:0] LOW_TOP = MEM_AW'(SHADOW_BASE);

  // R1
  ptr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == PTR_PORT) ##1 (io_rd_i && !io_wr_i && io_addr_i == PTR_PORT)
    |-> io_rdata_o == $past(io_wdata_i));

  // R7
  low_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_i < LOW_TOP) |-> (rd_int_o && wr_int_o));

  // R8
  a20_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !io_wr_i && io_addr_i == A20_PORT) |=> a20_en_o);

  // R8
  a20_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == A20_PORT) |=> !a20_en_o);

  // R9
  soft_rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == RST_PORT) |=> soft_rst_o);

  // R9
  soft_rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> $past(io_rd_i && io_addr_i == RST_PORT));

  // R10
  unhandled_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rd_i || (io_addr_i != PTR_PORT && io_addr_i != WIN_PORT))
    |-> io_rdata_o == 8'hFF);
endmodule

bind cfg_shadow_ctrl cfg_shadow_ctrl_chk #(
  .IO_BASE     (IO_BASE),
  .MEM_AW      (MEM_AW),
  .SHADOW_BASE (SHADOW_BASE)
) u_chk (.*);

// File: tb/cfg_shadow_ctrl_test.sv
`timescale 1ns/1ps
module cfg_shadow_ctrl_test;
  localparam logic [15:0] PTR = 16'h00EC;
  localparam logic [15:0] WIN = 16'h00ED;
  localparam logic [15:0] A20 = 16'h00EE;
  localparam logic [15:0] SRS = 16'h00EF;

  // sel: 0 rdata, 1 rd_int, 2 wr_int, 3 a20_en, 4 soft_rst
  typedef struct {
    int         due;
    int         sel;
    logic [7:0] exp;
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = '0;
  logic        rd_int, wr_int, a20_en, soft_rst;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_shadow_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
    .io_wr_i(io_wr), .io_rd_i(io_rd), .io_rdata_o(io_rdata), .mem_addr_i(mem_addr),
    .rd_int_o(rd_int), .wr_int_o(wr_int), .a20_en_o(a20_en), .soft_rst_o(soft_rst)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_v(input int sel, input logic [7:0] exp, input string req);
    exp_t e;
    e.due = cyc; e.sel = sel; e.exp = exp; e.req = req;
    q.push_back(e);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    step();
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [7:0] exp, input string req);
    io_addr = a; io_rd = 1'b1;
    expect_v(0, exp, req);
    step();
    io_rd = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
    io_write(PTR, idx);
    io_write(WIN, val);
  endtask

  task automatic cfg_read(input logic [7:0] idx, input logic [7:0] exp, input string req);
    io_write(PTR, idx);
    io_read(WIN, exp, req);
  endtask

  task automatic look(input logic [19:0] a, input logic rd, input logic wr, input string req);
    mem_addr = a;
    expect_v(1, {7'd0, rd}, req);
    expect_v(2, {7'd0, wr}, req);
    step();
  endtask

  // monitor: pops expectations due in the current cycle
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        logic [7:0] act;
        e = q.pop_front();
        case (e.sel)
          0: act = io_rdata;
          1: act = {7'd0, rd_int};
          2: act = {7'd0, wr_int};
          3: act = {7'd0, a20_en};
          default: act = {7'd0, soft_rst};
        endcase
        checks++;
        if (act !== e.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h", e.req, e.sel, act, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R11 reset state
    expect_v(3, 8'h00, "R11");
    expect_v(4, 8'h00, "R11");
    io_read(PTR, 8'h00, "R11");
    look(20'hC4000, 1'b0, 1'b0, "R11");
    look(20'hF8000, 1'b0, 1'b0, "R11");
    cfg_read(8'h24, 8'h00, "R11");

    // R1 pointer write and read back
    io_write(PTR, 8'h0F);
    io_read(PTR, 8'h0F, "R1");
    io_write(PTR, 8'hA7);
    io_read(PTR, 8'hA7, "R1");

    // R4 identification, R3 write at pointer 0 ignored
    cfg_read(8'h00, 8'h90, "R4");
    cfg_write(8'h00, 8'h55);
    cfg_read(8'h00, 8'h90, "R3");

    // R2 both edges of the writable band
    cfg_write(8'h01, 8'h3C);
    cfg_write(8'h24, 8'hA5);
    cfg_read(8'h01, 8'h3C, "R2");
    cfg_read(8'h24, 8'hA5, "R2");

    // R3 writes above the band ignored, R4 reads zero there
    cfg_write(8'h25, 8'h77);
    cfg_read(8'h25, 8'h00, "R3");
    cfg_write(8'hFF, 8'h81);
    cfg_read(8'hFF, 8'h00, "R4");
    cfg_read(8'h24, 8'hA5, "R3");

    // R5 / R6 ascending codes in segment A0000h
    cfg_write(8'h0D, 8'hE4);
    look(20'hA0000, 1'b0, 1'b0, "R6");
    look(20'hA4000, 1'b0, 1'b1, "R6");
    look(20'hA8000, 1'b1, 1'b0, "R6");
    look(20'hAFFFF, 1'b1, 1'b1, "R5");
    // descending codes in segment F0000h
    cfg_write(8'h12, 8'h1B);
    look(20'hF0000, 1'b1, 1'b1, "R5");
    look(20'hF7FFF, 1'b1, 1'b0, "R5");
    look(20'hF8000, 1'b0, 1'b1, "R5");
    look(20'hFFFFF, 1'b0, 1'b0, "R5");
    cfg_write(8'h0F, 8'hFF);
    look(20'hCFFFF, 1'b1, 1'b1, "R5");
    look(20'hB0000, 1'b0, 1'b0, "R5");
    look(20'hDC000, 1'b0, 1'b0, "R5");
    cfg_write(8'h11, 8'h80);
    look(20'hEC000, 1'b1, 1'b0, "R5");
    look(20'hE8000, 1'b0, 1'b0, "R5");

    // R7 below the shadow area
    look(20'h9FFFF, 1'b1, 1'b1, "R7");
    look(20'h00000, 1'b1, 1'b1, "R7");

    // R8 / R10 A20 gate
    io_read(A20, 8'hFF, "R10");
    expect_v(3, 8'h01, "R8");
    step();
    expect_v(3, 8'h01, "R8");
    io_write(A20, 8'h00);
    expect_v(3, 8'h00, "R8");
    io_addr = A20; io_rd = 1'b1; io_wr = 1'b1;
    step();
    io_rd = 1'b0; io_wr = 1'b0;
    expect_v(3, 8'h00, "R8");
    step();

    // R9 / R10 soft reset pulse
    expect_v(4, 8'h00, "R9");
    io_read(SRS, 8'hFF, "R10");
    expect_v(4, 8'h01, "R9");
    step();
    expect_v(4, 8'h00, "R9");
    step();

    // R10 unhandled port and idle bus
    io_read(16'h0080, 8'hFF, "R10");
    io_addr = PTR;
    expect_v(0, 8'hFF, "R10");
    step();

    step();
    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule